// File: doc/BRIEF.md
# Sign-Binarizing Sample Packer with Bipolar Template Scorer

This block turns a stream of signed fixed-point signal samples into one bit per sample. A sample above zero becomes a +1 code and anything else (zero included) becomes a -1 code. Eight codes are collected into a byte, with the earliest sample of the group in the lowest bit. Each finished byte leaves on an output stream and is scored at once against a stored binary template byte. The score is the count of agreeing bits minus the count of disagreeing bits, accumulated in a signed register for the whole window.

A window begins with a one-cycle `start` pulse, which also latches the window length in samples. Samples are offered with a valid/ready handshake. When the last sample of the window has been taken, any unfinished byte is zero-padded and sent with a partial flag. Two cycles after that last byte leaves, `done` pulses for one cycle and `score` holds the final result until the next `start`. The template is held in a memory outside the block with one cycle of read latency. The block drives the byte index on `tpl_addr`, and the memory returns the data on `tpl_byte`. All arithmetic is integer.

Top module: `sign_pack_corr`

## Requirements
- R1: A sample whose signed value is greater than zero is encoded as bit 1 (+1). A sample equal to zero or below zero is encoded as bit 0 (-1).
- R2: Eight consecutive accepted samples of a window form one byte. The first of the eight goes in bit 0 and the last in bit 7.
- R3: `out_valid` is high for exactly one cycle, in the cycle after the edge at which the eighth sample of a byte, or the final sample of the window, is accepted.
- R4: The final byte of a window raises `out_last`. If that byte holds fewer than 8 samples, its unused upper bits are 0 and `out_partial` is high with it.
- R5: `in_ready` is low while `out_valid` is high, so a sample offered then waits. Every sample accepted in a window appears in the emitted bytes; no sample is lost or repeated.
- R6: `tpl_addr` carries the index of the emitted byte (0 for the first byte of the window) from the cycle `out_valid` is high. It changes only in a cycle where `out_valid` is high. The template data is expected on `tpl_byte` one cycle after the address.
- R7: Each byte with n valid bits adds 2*a - n to the score, where a is the number of valid bit positions in which the data byte and the template byte agree (the popcount of their XNOR over those positions).
- R8: `done` is a one-cycle pulse that comes two cycles after the `out_valid` of the last byte. At that time `score` holds the sum for the whole window, and it stays there until the next `start`.
- R9: `start` clears the score, the bit and byte counters and any byte in flight, and it latches `win_len` (from 1 up to the maximum window). Between the end of a window and the next `start`, `in_ready` is low and offered samples have no effect.
- R10: After reset, `in_ready`, `out_valid` and `done` are low and `score` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Window start pulse; latches `win_len` |
| win_len | input | CNT_W | Samples in the window, 1..MAX_WIN |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample accepted when both are high |
| in_sample | input | SAMPLE_W | Signed sample |
| tpl_addr | output | IDX_W | Template byte index being scored |
| tpl_byte | input | 8 | Template byte, one cycle after `tpl_addr` |
| out_valid | output | 1 | Packed byte pulse |
| out_byte | output | 8 | Packed sign bits, first sample in bit 0 |
| out_last | output | 1 | Final byte of the window |
| out_partial | output | 1 | Final byte holds fewer than 8 samples |
| score | output | ACC_W | Signed bipolar correlation of the window |
| done | output | 1 | One-cycle pulse, score final |

## Verification
The assertions check on every cycle that bytes and `done` come as single-cycle pulses, that `in_ready` falls while a byte is out, that a partial flag only comes with a last byte, that `done` follows the last byte by exactly two cycles, that `start` clears the score, and that the template address moves only when a byte is emitted. Only the bench's scenarios can show that the packed bit values, their order and the zero padding are correct, and that the final score equals the arithmetic sum. It does this over every window length from 1 to the maximum, with and without gaps in `in_valid`, with zero and extreme samples, after a window is cut short by a new `start`, and with samples offered while the block is idle.

// File: rtl/spc_pkg.sv
package spc_pkg;

  // number of ones in a byte, 0..8
  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = 4'd0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/spc_packer.sv
module spc_packer #(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 7,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [CNT_W-1:0]    win_len,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                in_ready,
  output logic                out_valid,
  output logic [7:0]          out_byte,
  output logic [3:0]          out_nbits,
  output logic                out_last,
  output logic                out_partial,
  output logic [IDX_W-1:0]    out_idx
);

  logic             active;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [CNT_W-1:0] samp_cnt;
  logic [CNT_W-1:0] len_q;
  logic [IDX_W-1:0] byte_idx;

  logic       accept, sign_bit, is_full, is_last;
  logic [7:0] slot, merged;

  assign in_ready = active & ~out_valid;
  assign accept   = in_valid & in_ready;
  assign sign_bit = $signed(in_sample) > $signed({SAMPLE_W{1'b0}});
  assign slot     = 8'b0000_0001 << bit_cnt;
  assign merged   = sign_bit ? (shreg | slot) : shreg;
  assign is_full  = (bit_cnt == 3'd7);
  assign is_last  = ((samp_cnt + 1'b1) == len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active      <= 1'b0;
      bit_cnt     <= '0;
      shreg       <= '0;
      samp_cnt    <= '0;
      len_q       <= '0;
      byte_idx    <= '0;
      out_valid   <= 1'b0;
      out_byte    <= '0;
      out_nbits   <= '0;
      out_last    <= 1'b0;
      out_partial <= 1'b0;
      out_idx     <= '0;
    end else if (start) begin
      active    <= 1'b1;
      bit_cnt   <= '0;
      shreg     <= '0;
      samp_cnt  <= '0;
      len_q     <= win_len;
      byte_idx  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        samp_cnt <= samp_cnt + 1'b1;
        if (is_full || is_last) begin
          out_valid   <= 1'b1;
          out_byte    <= merged;
          out_nbits   <= {1'b0, bit_cnt} + 4'd1;
          out_last    <= is_last;
          out_partial <= is_last & ~is_full;
          out_idx     <= byte_idx;
          byte_idx    <= byte_idx + 1'b1;
          shreg       <= '0;
          bit_cnt     <= '0;
        end else begin
          shreg   <= merged;
          bit_cnt <= bit_cnt + 1'b1;
        end
        if (is_last) active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/spc_scorer.sv
module spc_scorer
  import spc_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic                    byte_valid,
  input  logic [7:0]              byte_data,
  input  logic [3:0]              byte_nbits,
  input  logic                    byte_last,
  input  logic [7:0]              tpl_byte,
  output logic signed [ACC_W-1:0] score,
  output logic                    done
);

  // stage 1 waits for the template read
  logic       sc_valid, sc_last;
  logic [7:0] sc_data;
  logic [3:0] sc_nbits;

  logic [7:0]              mask;
  logic [3:0]              agree;
  logic signed [ACC_W-1:0] corr;

  always_comb begin
    for (int i = 0; i < 8; i++) mask[i] = (i < int'(sc_nbits));
    agree = ones8(~(sc_data ^ tpl_byte) & mask);
    corr  = $signed({{(ACC_W-5){1'b0}}, agree, 1'b0})
          - $signed({{(ACC_W-4){1'b0}}, sc_nbits});
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      sc_valid <= 1'b0;
      sc_last  <= 1'b0;
      sc_data  <= '0;
      sc_nbits <= '0;
      score    <= '0;
      done     <= 1'b0;
    end else begin
      sc_valid <= byte_valid;
      sc_last  <= byte_last;
      sc_data  <= byte_data;
      sc_nbits <= byte_nbits;
      done     <= sc_valid & sc_last;
      if (sc_valid) score <= score + corr;
    end
  end

endmodule

// File: rtl/sign_pack_corr.sv
module sign_pack_corr #(
  parameter int SAMPLE_W = 12,
  parameter int MAX_WIN  = 64,
  localparam int CNT_W     = $clog2(MAX_WIN + 1),
  localparam int MAX_BYTES = (MAX_WIN + 7) / 8,
  localparam int IDX_W     = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int ACC_W     = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [CNT_W-1:0]        win_len,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [SAMPLE_W-1:0]     in_sample,
  output logic [IDX_W-1:0]        tpl_addr,
  input  logic [7:0]              tpl_byte,
  output logic                    out_valid,
  output logic [7:0]              out_byte,
  output logic                    out_last,
  output logic                    out_partial,
  output logic signed [ACC_W-1:0] score,
  output logic                    done
);

  logic [3:0] nbits;

  spc_packer #(
    .SAMPLE_W(SAMPLE_W),
    .CNT_W   (CNT_W),
    .IDX_W   (IDX_W)
  ) packer_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .win_len    (win_len),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_nbits  (nbits),
    .out_last   (out_last),
    .out_partial(out_partial),
    .out_idx    (tpl_addr)
  );

  spc_scorer #(
    .ACC_W(ACC_W)
  ) scorer_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .byte_valid(out_valid),
    .byte_data (out_byte),
    .byte_nbits(nbits),
    .byte_last (out_last),
    .tpl_byte  (tpl_byte),
    .score     (score),
    .done      (done)
  );

endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
  parameter int IDX_W = 3,
  parameter int ACC_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    in_ready,
  input logic [IDX_W-1:0]        tpl_addr,
  input logic                    out_valid,
  input logic                    out_last,
  input logic                    out_partial,
  input logic signed [ACC_W-1:0] score,
  input logic                    done
);

  // R3
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R5
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R4
  partial_last_chk: assert property (@(posedge clk) disable iff (rst)
    out_partial && out_valid |-> out_last);

  // R6
  addr_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(tpl_addr) |-> out_valid);

  // R8
  done_delay_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_last, 2));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (score == '0) && !done && !out_valid);

endmodule

bind sign_pack_corr spc_checker #(.IDX_W(IDX_W), .ACC_W(ACC_W)) chk_i (.*);

// File: tb/sign_pack_corr_tb_top.sv
module sign_pack_corr_tb_top;

  localparam int SW = 12;
  localparam int MW = 64;
  localparam int CW = $clog2(MW + 1);
  localparam int NB = (MW + 7) / 8;
  localparam int IW = $clog2(NB);
  localparam int AW = CW + 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst, start, in_valid, in_ready;
  logic [CW-1:0]        win_len;
  logic [SW-1:0]        in_sample;
  logic [IW-1:0]        tpl_addr;
  logic [7:0]           tpl_byte;
  logic                 out_valid, out_last, out_partial, done;
  logic [7:0]           out_byte;
  logic signed [AW-1:0] score;

  sign_pack_corr #(.SAMPLE_W(SW), .MAX_WIN(MW)) dut_i (.*);

  logic [7:0] tpl_mem [NB];
  always @(posedge clk) tpl_byte <= tpl_mem[tpl_addr];

  int checks = 0, fails = 0;
  logic [31:0] lcg = 32'h1234_5678;

  function automatic logic [31:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg >> 7;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic signed [SW-1:0] smp [MW];
  logic [7:0] eb [NB];
  int enb [NB];
  int escore, nbytes;

  task automatic make_window(input int len);
    for (int i = 0; i < len; i++) begin
      logic [31:0] r = rnd();
      if (i == 1) smp[i] = 12'sd2047;
      else if (i == 2) smp[i] = -12'sd2048;
      else if (r[1:0] == 2'd0) smp[i] = '0;
      else smp[i] = r[SW+3:4];
    end
    nbytes = (len + 7) / 8;
    escore = 0;
    for (int k = 0; k < NB; k++) begin
      logic [31:0] r = rnd();
      tpl_mem[k] = r[7:0];
    end
    for (int k = 0; k < nbytes; k++) begin
      eb[k] = 8'h00;
      enb[k] = 0;
      for (int b = 0; b < 8; b++) begin
        if (k * 8 + b < len) begin
          if (smp[k*8+b] > 0) eb[k][b] = 1'b1;
          enb[k]++;
          escore += (eb[k][b] == tpl_mem[k][b]) ? 1 : -1;
        end
      end
    end
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk);
    start = 1'b1; win_len = CW'(len); in_valid = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(score == 0 && !done, "R9 score cleared", int'(score), 0);
  endtask

  task automatic run_window(input int len, input int gap);
    int idx = 0, ob = 0, cyc = 0, lastc = -10;
    bit got = 0;
    make_window(len);
    pulse_start(len);
    for (int guard = 0; guard < 4000 && !got; guard++) begin
      if (out_valid) begin
        chk(out_byte == eb[ob], "R1 R2 byte", out_byte, eb[ob]);
        chk(out_last == (ob == nbytes - 1), "R4 last", out_last, ob == nbytes - 1);
        chk(out_partial == ((ob == nbytes - 1) && (len % 8 != 0)), "R4 partial",
            out_partial, (ob == nbytes - 1) && (len % 8 != 0));
        chk(int'(tpl_addr) == ob, "R6 addr", tpl_addr, ob);
        chk(!in_ready, "R5 ready low", in_ready, 0);
        if (out_last) lastc = cyc;
        ob++;
      end
      if (done) begin
        chk(int'(score) == escore, "R7 score", score, escore);
        chk(cyc == lastc + 2, "R8 done timing", cyc - lastc, 2);
        chk(ob == nbytes && idx == len, "R5 all samples", idx, len);
        got = 1;
      end
      if (idx < len && (gap == 0 || rnd() % 3 != 0)) begin
        in_valid = 1'b1; in_sample = smp[idx];
      end else begin
        in_valid = 1'b0;
      end
      if (in_valid && in_ready) idx++;
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0;
    if (!got) chk(0, "R8 watchdog", 0, 1);
    chk(!done && int'(score) == escore, "R8 score held", score, escore);
    // samples offered while idle must do nothing
    for (int j = 0; j < 4; j++) begin
      in_valid = 1'b1; in_sample = 12'sd100;
      chk(!in_ready, "R9 idle ready", in_ready, 0);
      @(negedge clk);
      chk(!out_valid && !done && int'(score) == escore, "R9 idle ignored", score, escore);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; win_len = '0; in_valid = 1'b0; in_sample = '0;
    for (int k = 0; k < NB; k++) tpl_mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!in_ready && !out_valid && !done && score == 0, "R10 reset", int'(score), 0);
    // window cut short by a fresh start
    pulse_start(40);
    for (int j = 0; j < 12; j++) begin
      in_valid = 1'b1; in_sample = 12'sd5;
      @(negedge clk);
    end
    in_valid = 1'b0;
    run_window(17, 1);
    for (int len = 1; len <= MW; len++) begin
      run_window(len, 0);
      run_window(len, 1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule